// File: doc/BRIEF.md
# Integer condition code generator

This block produces the four integer condition flags of a CISC-style processor after an integer operation has run in the datapath. The arithmetic is done elsewhere; the block receives the operation class, the operand size, both source operands and the already computed result, and from them derives negative, zero, overflow and carry at byte, word or longword width. Results wider than a longword (quad, octa) arrive as several longwords on a wide result bus, and only the sign and zero flags are derived from them.

The block also maintains the combined trap/priority byte. An operation that sets overflow while the integer overflow enable is on posts the integer overflow trap code into that byte, and a separate clear-traps command wipes any pending trap code. In both cases the interrupt priority field is left as it was. Both the flag nibble and the trap/priority byte are registered. They change only on a strobed operation or a clear command.

Top module: `ccgen`

## Requirements
- R1: A synchronous, active-high reset drives `cc_q` and `tw_q` to zero on the next clock edge.
- R2: On an edge where `valid` is low, `cc_q` keeps its value. On an edge where both `valid` and `clr_traps` are low, `tw_q` also keeps its value.
- R3: `cc_q` packs the flags as N=bit 3, Z=bit 2, V=bit 1, C=bit 0. For ADD, SUB, MOV and TST, N is the result's sign bit at the selected size (bit 7 for byte, size 0; bit 15 for word, size 1; bit 31 for long, size 2) and Z is set when the result, masked to that size, is zero. N and Z are never both set.
- R4: With size 3 (multi-longword), Z is set only when every longword of `result` is zero, and N is bit 31 of the most significant longword. The arithmetic V/C tests use longword width at this size.
- R5: ADD (op 0): V is set when both operands carry the same sign and the result's sign differs from it. C is set when the masked result is unsigned-less-than the masked second operand `src_b`.
- R6: SUB (op 1) computes `src_b - src_a`. V is set when the operands differ in sign and the result's sign equals the sign of `src_a`. C is set when masked `src_b` is unsigned-less-than masked `src_a`.
- R7: CMP (op 2) ignores `result`. N is set when `src_a` is signed-less-than `src_b` after sign extension from the selected size. Z is set when the masked operands are equal. V is cleared, and C is set when masked `src_a` is unsigned-less-than masked `src_b`.
- R8: MOV (op 3) sets N and Z from the result, clears V and copies C from `cc_in` bit 0.
- R9: TST (op 4) sets N and Z from the result and clears V and C. The unassigned op codes 5 to 7 behave like TST.
- R10: On a strobed operation that sets V while `iov_en` is 1, `tw_q` bits 7:5 become 3'b001. Otherwise a strobed operation copies `tw_in` into `tw_q`. Bits 4:0 of `tw_q` are always taken from `tw_in`.
- R11: A `clr_traps` edge zeroes `tw_q` bits 7:5 and takes bits 4:0 from `tw_in`, with or without `valid`. If the same edge also posts an overflow, code 1 is written. A `clr_traps` edge without `valid` leaves `cc_q` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Strobe: an operation's flags are to be captured |
| clr_traps | input | 1 | Clear pending trap code in the trap/priority byte |
| op | input | 3 | Operation class: 0 ADD, 1 SUB, 2 CMP, 3 MOV, 4 TST |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 long, 3 multi-longword |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| result | input | NUM_LW*32 | Operation result, longword 0 in the low bits |
| cc_in | input | 4 | Previous flag nibble |
| iov_en | input | 1 | Integer overflow trap enable from the status word |
| tw_in | input | 8 | Current trap/priority byte |
| cc_q | output | 4 | Registered flag nibble |
| tw_q | output | 8 | Registered updated trap/priority byte |

## Verification
The case that is hardest to reach from the ports is a clear-traps command that lands on the same edge as an overflowing operation with the trap enabled. Clear and post then compete for the same three bits while the priority bits must pass through untouched. The bench drives this directly with a nonzero trap code and a nonzero priority already on `tw_in`, and it also runs clear alone and clear with a non-overflowing strobe. Multi-longword zero detection is exercised with a result whose only nonzero longword is an inner one, and with one whose only sign bit sits in the lowest longword, so that an implementation looking at the wrong longword shows up as a wrong flag.

// File: rtl/ccgen_pkg.sv
package ccgen_pkg;

    localparam int unsigned LW = 32;

    typedef enum logic [2:0] {
        CC_OP_ADD = 3'd0,
        CC_OP_SUB = 3'd1,
        CC_OP_CMP = 3'd2,
        CC_OP_MOV = 3'd3,
        CC_OP_TST = 3'd4
    } cc_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_MULTI = 2'd3
    } sz_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam logic [2:0] TRAP_CODE_IOVF = 3'd1;

    // Zero every bit above the selected operand size.
    function automatic logic [LW-1:0] sz_mask(input logic [LW-1:0] x, input sz_e s);
        case (s)
            SZ_BYTE: sz_mask = {24'd0, x[7:0]};
            SZ_WORD: sz_mask = {16'd0, x[15:0]};
            default: sz_mask = x;
        endcase
    endfunction

    // Sign bit at the selected operand size.
    function automatic logic sz_sign(input logic [LW-1:0] x, input sz_e s);
        case (s)
            SZ_BYTE: sz_sign = x[7];
            SZ_WORD: sz_sign = x[15];
            default: sz_sign = x[LW-1];
        endcase
    endfunction

    // Sign-extend from the selected size to a full longword.
    function automatic logic [LW-1:0] sz_sext(input logic [LW-1:0] x, input sz_e s);
        case (s)
            SZ_BYTE: sz_sext = {{24{x[7]}}, x[7:0]};
            SZ_WORD: sz_sext = {{16{x[15]}}, x[15:0]};
            default: sz_sext = x;
        endcase
    endfunction

endpackage

// File: rtl/ccgen_nz.sv
module ccgen_nz
    import ccgen_pkg::*;
#(
    parameter int unsigned NUM_LW = 4
) (
    input  cc_op_e                 op,
    input  sz_e                    size,
    input  logic [LW-1:0]          src_a,
    input  logic [LW-1:0]          src_b,
    input  logic [NUM_LW*LW-1:0]   result,
    output logic                   n_out,
    output logic                   z_out
);
    localparam int unsigned RW = NUM_LW * LW;

    // Running OR of the longwords, one stage per longword.
    logic [LW-1:0] lw_or [NUM_LW];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LW; gi++) begin : g_or
            if (gi == 0) begin : g_first
                assign lw_or[gi] = result[LW-1:0];
            end else begin : g_next
                assign lw_or[gi] = lw_or[gi-1] | result[gi*LW +: LW];
            end
        end
    endgenerate

    logic multi_zero;
    logic multi_neg;
    assign multi_zero = (lw_or[NUM_LW-1] == '0);
    assign multi_neg  = result[RW-1];

    always_comb begin
        if (op == CC_OP_CMP) begin
            n_out = $signed(sz_sext(src_a, size)) < $signed(sz_sext(src_b, size));
            z_out = sz_mask(src_a, size) == sz_mask(src_b, size);
        end else if (size == SZ_MULTI) begin
            n_out = multi_neg;
            z_out = multi_zero;
        end else begin
            n_out = sz_sign(result[LW-1:0], size);
            z_out = sz_mask(result[LW-1:0], size) == '0;
        end
    end

endmodule

// File: rtl/ccgen_vc.sv
module ccgen_vc
    import ccgen_pkg::*;
(
    input  cc_op_e        op,
    input  sz_e           size,
    input  logic [LW-1:0] src_a,
    input  logic [LW-1:0] src_b,
    input  logic [LW-1:0] res_lo,
    input  logic          c_prev,
    output logic          v_out,
    output logic          c_out
);
    sz_e           esz;
    logic [LW-1:0] am, bm, rm;
    logic          sa, sb, sr;

    // Multi-longword arithmetic is judged at longword width.
    assign esz = (size == SZ_MULTI) ? SZ_LONG : size;
    assign am  = sz_mask(src_a, esz);
    assign bm  = sz_mask(src_b, esz);
    assign rm  = sz_mask(res_lo, esz);
    assign sa  = sz_sign(src_a, esz);
    assign sb  = sz_sign(src_b, esz);
    assign sr  = sz_sign(res_lo, esz);

    always_comb begin
        case (op)
            CC_OP_ADD: begin
                v_out = (sa == sb) && (sr != sa);
                c_out = rm < bm;
            end
            CC_OP_SUB: begin
                // result = src_b - src_a
                v_out = (sa != sb) && (sr == sa);
                c_out = bm < am;
            end
            CC_OP_CMP: begin
                v_out = 1'b0;
                c_out = am < bm;
            end
            CC_OP_MOV: begin
                v_out = 1'b0;
                c_out = c_prev;
            end
            default: begin
                v_out = 1'b0;
                c_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ccgen_trapword.sv
module ccgen_trapword
    import ccgen_pkg::*;
#(
    parameter int unsigned TW_W   = 8,
    parameter int unsigned PRIO_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic            clr_traps,
    input  logic            ovf,
    input  logic            iov_en,
    input  logic [TW_W-1:0] tw_in,
    output logic [TW_W-1:0] tw_q
);
    localparam int unsigned CODE_W = TW_W - PRIO_W;

    logic [TW_W-1:0] base;
    logic [TW_W-1:0] tw_nxt;
    logic            post;

    assign post = valid && ovf && iov_en;
    assign base = clr_traps ? {{CODE_W{1'b0}}, tw_in[PRIO_W-1:0]} : tw_in;

    always_comb begin
        tw_nxt = base;
        if (post) tw_nxt = {TRAP_CODE_IOVF, base[PRIO_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst)                     tw_q <= '0;
        else if (valid || clr_traps) tw_q <= tw_nxt;
    end

    assert_post_code_R10: assert property (@(posedge clk) disable iff (rst)
        (valid && ovf && iov_en) |=> (tw_q[TW_W-1:PRIO_W] == TRAP_CODE_IOVF));

    assert_keep_prio_R10: assert property (@(posedge clk) disable iff (rst)
        (valid || clr_traps) |=> (tw_q[PRIO_W-1:0] == $past(tw_in[PRIO_W-1:0])));

    assert_clear_code_R11: assert property (@(posedge clk) disable iff (rst)
        (clr_traps && !(valid && ovf && iov_en)) |=> (tw_q[TW_W-1:PRIO_W] == '0));

    assert_hold_tw_R2: assert property (@(posedge clk) disable iff (rst)
        (!valid && !clr_traps) |=> $stable(tw_q));

endmodule

// File: rtl/ccgen.sv
module ccgen
    import ccgen_pkg::*;
#(
    parameter int unsigned NUM_LW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  logic                 clr_traps,
    input  logic [2:0]           op,
    input  logic [1:0]           size,
    input  logic [31:0]          src_a,
    input  logic [31:0]          src_b,
    input  logic [NUM_LW*32-1:0] result,
    input  logic [3:0]           cc_in,
    input  logic                 iov_en,
    input  logic [7:0]           tw_in,
    output logic [3:0]           cc_q,
    output logic [7:0]           tw_q
);
    cc_op_e op_e;
    sz_e    sz;
    flags_t nxt;
    flags_t prev;

    assign op_e = cc_op_e'(op);
    assign sz   = sz_e'(size);
    assign prev = flags_t'(cc_in);

    ccgen_nz #(.NUM_LW(NUM_LW)) nz_i (
        .op     (op_e),
        .size   (sz),
        .src_a  (src_a),
        .src_b  (src_b),
        .result (result),
        .n_out  (nxt.n),
        .z_out  (nxt.z)
    );

    ccgen_vc vc_i (
        .op     (op_e),
        .size   (sz),
        .src_a  (src_a),
        .src_b  (src_b),
        .res_lo (result[31:0]),
        .c_prev (prev.c),
        .v_out  (nxt.v),
        .c_out  (nxt.c)
    );

    ccgen_trapword #(.TW_W(8), .PRIO_W(5)) tw_i (
        .clk       (clk),
        .rst       (rst),
        .valid     (valid),
        .clr_traps (clr_traps),
        .ovf       (nxt.v),
        .iov_en    (iov_en),
        .tw_in     (tw_in),
        .tw_q      (tw_q)
    );

    always_ff @(posedge clk) begin
        if (rst)        cc_q <= '0;
        else if (valid) cc_q <= nxt;
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (cc_q == 4'd0 && tw_q == 8'd0));

    assert_hold_cc_R2: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(cc_q));

    assert_nz_excl_R3: assert property (@(posedge clk) disable iff (rst)
        cc_q[3] |-> !cc_q[2]);

    assert_cmp_nov_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && op == 3'd2) |=> !cc_q[1]);

    assert_mov_keepc_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && op == 3'd3) |=> (cc_q[0] == $past(cc_in[0]) && !cc_q[1]));

    assert_tst_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && op == 3'd4) |=> (cc_q[1:0] == 2'b00));

endmodule

// File: tb/ccgen_tb_top.sv
module ccgen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_LW     = 4;
    localparam int RW         = NUM_LW * 32;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic [3:0]  ccin;
        logic        iov;
        logic [7:0]  twin;
        logic [3:0]  ecc;
        logic [7:0]  etw;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 32'h7F,       32'h01,       32'h80,       4'h0, 1'b1, 8'h05, 4'hA, 8'h25, 8'd5},  // R5 byte ovf, post
        '{3'd0, 2'd0, 32'hFF,       32'h01,       32'h00,       4'h0, 1'b0, 8'h1F, 4'h5, 8'h1F, 8'd5},  // R5 carry, zero
        '{3'd0, 2'd1, 32'h8000,     32'h8000,     32'h0,        4'h0, 1'b1, 8'h00, 4'h7, 8'h20, 8'd5},  // R5 word neg+neg
        '{3'd0, 2'd2, 32'h1,        32'h2,        32'h3,        4'h0, 1'b1, 8'hE3, 4'h0, 8'hE3, 8'd10}, // R10 no V, copy
        '{3'd1, 2'd0, 32'h01,       32'h00,       32'hFF,       4'h0, 1'b0, 8'h00, 4'h9, 8'h00, 8'd6},  // R6 borrow
        '{3'd1, 2'd0, 32'h01,       32'h80,       32'h7F,       4'h0, 1'b1, 8'h0A, 4'h2, 8'h2A, 8'd6},  // R6 overflow
        '{3'd1, 2'd1, 32'h5,        32'h5,        32'h0,        4'h0, 1'b0, 8'h00, 4'h4, 8'h00, 8'd6},  // R6 equal
        '{3'd1, 2'd2, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 4'h0, 1'b0, 8'h03, 4'hB, 8'h03, 8'd10}, // R10 V, trap off
        '{3'd2, 2'd0, 32'h80,       32'h01,       32'h55,       4'h0, 1'b0, 8'h00, 4'h8, 8'h00, 8'd7},  // R7 signed less
        '{3'd2, 2'd0, 32'h301,      32'h1FF,      32'h0,        4'h0, 1'b0, 8'h00, 4'h1, 8'h00, 8'd7},  // R7 unsigned less, masked
        '{3'd2, 2'd1, 32'hFFFF1234, 32'h00001234, 32'h0,        4'h0, 1'b0, 8'h00, 4'h4, 8'h00, 8'd7},  // R7 equal after mask
        '{3'd2, 2'd2, 32'h80000000, 32'h7FFFFFFF, 32'h0,        4'h0, 1'b1, 8'h07, 4'h8, 8'h07, 8'd7},  // R7 long
        '{3'd3, 2'd1, 32'h0,        32'h0,        32'h8000,     4'hF, 1'b0, 8'h00, 4'h9, 8'h00, 8'd8},  // R8 keep C=1
        '{3'd3, 2'd2, 32'h0,        32'h0,        32'h0,        4'h2, 1'b1, 8'h11, 4'h4, 8'h11, 8'd8},  // R8 clear V
        '{3'd4, 2'd0, 32'h0,        32'h0,        32'h1FF,      4'hF, 1'b0, 8'h00, 4'h8, 8'h00, 8'd9},  // R9 byte neg
        '{3'd4, 2'd2, 32'h0,        32'h0,        32'h0,        4'h3, 1'b0, 8'h00, 4'h4, 8'h00, 8'd9},  // R9 zero
        '{3'd5, 2'd2, 32'h0,        32'h0,        32'h1,        4'hF, 1'b0, 8'h00, 4'h0, 8'h00, 8'd9}   // R9 unassigned op
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic          clr_traps = 1'b0;
    logic [2:0]    op = '0;
    logic [1:0]    size = '0;
    logic [31:0]   src_a = '0;
    logic [31:0]   src_b = '0;
    logic [RW-1:0] result = '0;
    logic [3:0]    cc_in = '0;
    logic          iov_en = 1'b0;
    logic [7:0]    tw_in = '0;
    logic [3:0]    cc_q;
    logic [7:0]    tw_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccgen #(.NUM_LW(NUM_LW)) dut_i (
        .clk(clk), .rst(rst), .valid(valid), .clr_traps(clr_traps),
        .op(op), .size(size), .src_a(src_a), .src_b(src_b), .result(result),
        .cc_in(cc_in), .iov_en(iov_en), .tw_in(tw_in), .cc_q(cc_q), .tw_q(tw_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, capture at the rising edge, sample at the next falling edge.
    task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic [31:0] a,
                         input logic [31:0] b, input logic [RW-1:0] r, input logic [3:0] ci,
                         input logic ie, input logic [7:0] ti, input logic v, input logic cl);
        @(negedge clk);
        op = o; size = s; src_a = a; src_b = b; result = r;
        cc_in = ci; iov_en = ie; tw_in = ti; valid = v; clr_traps = cl;
        @(negedge clk);
        valid = 1'b0; clr_traps = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] held_cc;
        logic [7:0] held_tw;

        repeat (3) @(negedge clk);
        check("R1 reset cc", {28'd0, cc_q}, 32'h0);
        check("R1 reset tw", {24'd0, tw_q}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].sz, VECS[i].a, VECS[i].b, {{(RW-32){1'b0}}, VECS[i].r},
                  VECS[i].ccin, VECS[i].iov, VECS[i].twin, 1'b1, 1'b0);
            checks++;
            if (cc_q !== VECS[i].ecc) begin
                errors++;
                $display("FAIL R%0d vec %0d cc: actual %h expected %h", VECS[i].req, i, cc_q, VECS[i].ecc);
            end
            checks++;
            if (tw_q !== VECS[i].etw) begin
                errors++;
                $display("FAIL R%0d vec %0d tw: actual %h expected %h", VECS[i].req, i, tw_q, VECS[i].etw);
            end
        end

        // R3: N and Z must not appear together; last vector leaves zero flags, use a negative word.
        apply(3'd4, 2'd1, 32'h0, 32'h0, {{(RW-32){1'b0}}, 32'h0001_8000}, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R3 word sign only", {28'd0, cc_q}, 32'h8);

        // R4: multi-longword sign and zero.
        apply(3'd4, 2'd3, 32'h0, 32'h0, '0, 4'hF, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R4 all zero", {28'd0, cc_q}, 32'h4);
        apply(3'd3, 2'd3, 32'h0, 32'h0, {{(RW-65){1'b0}}, 1'b1, 64'h0}, 4'h1, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R4 inner word nonzero", {28'd0, cc_q}, 32'h1);
        apply(3'd4, 2'd3, 32'h0, 32'h0, {1'b1, {(RW-1){1'b0}}}, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R4 top sign", {28'd0, cc_q}, 32'h8);
        apply(3'd4, 2'd3, 32'h0, 32'h0, {{(RW-32){1'b0}}, 32'h8000_0000}, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R4 low sign ignored", {28'd0, cc_q}, 32'h0);

        // R2: without a strobe nothing moves.
        apply(3'd0, 2'd0, 32'h7F, 32'h01, {{(RW-32){1'b0}}, 32'h80}, 4'h0, 1'b1, 8'h05, 1'b1, 1'b0);
        held_cc = cc_q; held_tw = tw_q;
        check("R2 setup cc", {28'd0, held_cc}, 32'hA);
        apply(3'd4, 2'd2, 32'h0, 32'h0, '0, 4'hF, 1'b1, 8'hFF, 1'b0, 1'b0);
        check("R2 hold cc", {28'd0, cc_q}, {28'd0, held_cc});
        check("R2 hold tw", {24'd0, tw_q}, {24'd0, held_tw});

        // R11: clear alone, clear with overflow post, clear with plain strobe.
        apply(3'd4, 2'd2, 32'h0, 32'h0, '0, 4'h0, 1'b0, 8'hFF, 1'b0, 1'b1);
        check("R11 clear alone tw", {24'd0, tw_q}, 32'h1F);
        check("R11 clear alone cc", {28'd0, cc_q}, {28'd0, held_cc});
        apply(3'd0, 2'd0, 32'h7F, 32'h01, {{(RW-32){1'b0}}, 32'h80}, 4'h0, 1'b1, 8'hE4, 1'b1, 1'b1);
        check("R11 clear+post tw", {24'd0, tw_q}, 32'h24);
        apply(3'd0, 2'd2, 32'h1, 32'h1, {{(RW-32){1'b0}}, 32'h2}, 4'h0, 1'b1, 8'hE4, 1'b1, 1'b1);
        check("R11 clear+strobe tw", {24'd0, tw_q}, 32'h04);
        check("R11 clear+strobe cc", {28'd0, cc_q}, 32'h0);

        // R1: reset in mid-run.
        apply(3'd3, 2'd2, 32'h0, 32'h0, {{(RW-32){1'b0}}, 32'h8000_0000}, 4'h1, 1'b0, 8'hC7, 1'b1, 1'b0);
        check("R8 pre-reset cc", {28'd0, cc_q}, 32'h9);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 mid reset cc", {28'd0, cc_q}, 32'h0);
        check("R1 mid reset tw", {24'd0, tw_q}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule